// File: doc/BRIEF.md
# Multicycle RISC Execution Sequencer

This block is a small integer core that runs a fixed-length 32-bit RISC subset one instruction at a time. It has no pipeline. Each instruction moves through a fixed series of states: fetch, decode with register read, execute or address formation, memory access, and write-back. An instruction leaves the sequence as soon as its class has no further work to do, so different classes take different numbers of cycles.

Instruction fetch and data access use separate memory ports. Both memories answer in the same cycle as the request, and the surrounding system supplies them. The core has 32 general registers. A one-cycle retire pulse and a free-running cycle counter let a harness measure the exact cost of every instruction class.

Top module: `mc_risc_seq`

## Requirements
- R1: While reset is held and in the first cycle after release, the fetch address is 0, the cycle counter is 0, and retire and the data write strobe are low.
- R2: Fetch reads the word at the program counter. Every instruction other than a taken branch leaves the program counter at its own address plus 4.
- R3: Fields: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0], immediate [15:0]. The immediate is sign-extended by copying bit 15 into bits 31:16.
- R4: Opcode 0x00 is register-register: funct 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x26 xor, 0x2A signed set-less-than. Any other funct gives 0. The result goes to rd, and the instruction takes 5 cycles.
- R5: Opcodes 0x08 add, 0x0C and, 0x0D or combine rs with the sign-extended immediate. The result goes to rt, and the instruction takes 5 cycles.
- R6: Opcode 0x23 loads the data word at rs plus the sign-extended immediate into rt, and takes 5 cycles.
- R7: Opcode 0x2B writes rt to the data word at rs plus the sign-extended immediate, with exactly one write strobe, and takes 4 cycles.
- R8: Opcode 0x04 compares rs and rt. If they are equal, the next program counter is PC+4 plus the immediate shifted left by 2. If not, it is PC+4. The branch takes 2 cycles and changes no register or memory word.
- R9: Register 0 reads as zero, and writes to it are dropped.
- R10: Any other opcode retires after 2 cycles and has no effect except advancing the program counter by 4.
- R11: Retire is high for exactly one cycle, in the final state of each instruction. The cycle counter rises by one on every clock after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| imemAddr | output | 32 | Instruction fetch byte address (program counter) |
| imemRdata | input | 32 | Instruction word at imemAddr, same cycle |
| dmemAddr | output | 32 | Data byte address |
| dmemWdata | output | 32 | Store data |
| dmemRdata | input | 32 | Load data at dmemAddr, same cycle |
| dmemRead | output | 1 | Data read strobe |
| dmemWrite | output | 1 | Data write strobe |
| retire | output | 1 | Instruction completes this cycle |
| cycleCount | output | 32 | Clocks since reset release |

## Verification
The assertions take three things for granted. Both memories return data combinationally in the cycle of the request. Instruction and data addresses stay word aligned. Each fetched word is held steady until the next fetch. The stimulus keeps to these limits in three ways. Every program is laid out on word boundaries in a bench-modelled memory. All stores and loads use addresses that are multiples of four inside that memory. The program ends in a branch to itself, so the core never fetches from outside the loaded image.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int XLEN = 32;

  typedef enum logic [2:0] {ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WB} stateT;
  typedef enum logic [2:0] {CL_RR, CL_RI, CL_LOAD, CL_STORE, CL_BRANCH, CL_NOP} classT;

  localparam logic [5:0] OP_RR    = 6'h00;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_ANDI  = 6'h0C;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_XOR = 6'h26;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef struct packed {
    logic irLoad;
    logic opLoad;
    logic aluLoad;
    logic lmdLoad;
    logic memRead;
    logic memWrite;
    logic regWrite;
    logic pcLoad;
    logic pcTarget;
  } strobeT;

  function automatic classT classOf(input logic [5:0] op);
    case (op)
      OP_RR:                   return CL_RR;
      OP_ADDI, OP_ANDI, OP_ORI: return CL_RI;
      OP_LOAD:                 return CL_LOAD;
      OP_STORE:                return CL_STORE;
      OP_BEQ:                  return CL_BRANCH;
      default:                 return CL_NOP;
    endcase
  endfunction
endpackage

// File: rtl/mcs_ctrl.sv
module mcs_ctrl
  import mcs_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [5:0]   opcode,
  input  logic         regsEq,
  output strobeT       stb,
  output logic         retire
);
  stateT st, stNext;
  classT cls;

  assign cls = classOf(opcode);

  always_comb begin
    stNext = st;
    stb    = '0;
    retire = 1'b0;
    case (st)
      ST_FETCH: begin
        stb.irLoad = 1'b1;
        stNext     = ST_DECODE;
      end
      ST_DECODE: begin
        stb.opLoad = 1'b1;
        if (cls == CL_BRANCH || cls == CL_NOP) begin
          retire       = 1'b1;
          stb.pcLoad   = 1'b1;
          stb.pcTarget = (cls == CL_BRANCH) && regsEq;
          stNext       = ST_FETCH;
        end else begin
          stNext = ST_EXEC;
        end
      end
      ST_EXEC: begin
        stb.aluLoad = 1'b1;
        stNext      = ST_MEM;
      end
      ST_MEM: begin
        if (cls == CL_STORE) begin
          stb.memWrite = 1'b1;
          stb.pcLoad   = 1'b1;
          retire       = 1'b1;
          stNext       = ST_FETCH;
        end else begin
          stb.memRead = (cls == CL_LOAD);
          stb.lmdLoad = (cls == CL_LOAD);
          stNext      = ST_WB;
        end
      end
      ST_WB: begin
        stb.regWrite = 1'b1;
        stb.pcLoad   = 1'b1;
        retire       = 1'b1;
        stNext       = ST_FETCH;
      end
      default: stNext = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_FETCH;
    else       st <= stNext;
  end

  AST_BRANCH_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rstN)
    (retire && cls == CL_BRANCH) |-> $past(stb.irLoad)); // R8
  AST_STORE_FOUR_CYCLES: assert property (@(posedge clk) disable iff (!rstN)
    stb.memWrite |-> ($past(stb.aluLoad) && retire)); // R7
  AST_LOAD_WRITEBACK: assert property (@(posedge clk) disable iff (!rstN)
    stb.lmdLoad |=> (stb.regWrite && retire)); // R6
  AST_RETIRE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    retire |=> !retire); // R11
endmodule

// File: rtl/mcs_dpath.sv
module mcs_dpath
  import mcs_pkg::*;
#(
  parameter int REGS = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobeT          stb,
  input  logic [XLEN-1:0] imemRdata,
  input  logic [XLEN-1:0] dmemRdata,
  output logic [XLEN-1:0] pc,
  output logic [5:0]      opcode,
  output logic            regsEq,
  output logic [XLEN-1:0] dmemAddr,
  output logic [XLEN-1:0] dmemWdata
);
  localparam int IDX_W = $clog2(REGS);

  logic [XLEN-1:0] npc, ir, opA, opB, imm, aluOut, lmd;
  logic [XLEN-1:0] regs [REGS];
  logic [XLEN-1:0] rdA, rdB, immSx, aluRes, wbData;
  logic [IDX_W-1:0] rsIdx, rtIdx, rdIdx, dstIdx;
  logic [5:0] funct;
  classT cls;
  logic unusedBits;

  assign opcode = ir[31:26];
  assign funct  = ir[5:0];
  assign rsIdx  = ir[21 +: IDX_W];
  assign rtIdx  = ir[16 +: IDX_W];
  assign rdIdx  = ir[11 +: IDX_W];
  assign immSx  = {{(XLEN-16){ir[15]}}, ir[15:0]};
  assign cls    = classOf(opcode);
  assign unusedBits = ^ir[10:6];

  assign rdA    = (rsIdx == '0) ? '0 : regs[rsIdx];
  assign rdB    = (rtIdx == '0) ? '0 : regs[rtIdx];
  assign regsEq = (rdA == rdB);

  always_comb begin
    aluRes = opA + imm;
    case (cls)
      CL_RR: begin
        case (funct)
          FN_ADD:  aluRes = opA + opB;
          FN_SUB:  aluRes = opA - opB;
          FN_AND:  aluRes = opA & opB;
          FN_OR:   aluRes = opA | opB;
          FN_XOR:  aluRes = opA ^ opB;
          FN_SLT:  aluRes = {{(XLEN-1){1'b0}}, ($signed(opA) < $signed(opB))};
          default: aluRes = '0;
        endcase
      end
      CL_RI: begin
        case (opcode)
          OP_ANDI: aluRes = opA & imm;
          OP_ORI:  aluRes = opA | imm;
          default: aluRes = opA + imm;
        endcase
      end
      default: aluRes = opA + imm;
    endcase
  end

  assign dstIdx    = (cls == CL_RR) ? rdIdx : rtIdx;
  assign wbData    = (cls == CL_LOAD) ? lmd : aluOut;
  assign dmemAddr  = aluOut;
  assign dmemWdata = opB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc     <= '0;
      npc    <= '0;
      ir     <= '0;
      opA    <= '0;
      opB    <= '0;
      imm    <= '0;
      aluOut <= '0;
      lmd    <= '0;
      for (int i = 0; i < REGS; i++) regs[i] <= '0;
    end else begin
      if (stb.irLoad) begin
        ir  <= imemRdata;
        npc <= pc + 32'd4;
      end
      if (stb.opLoad) begin
        opA <= rdA;
        opB <= rdB;
        imm <= immSx;
      end
      if (stb.aluLoad) aluOut <= aluRes;
      if (stb.lmdLoad) lmd <= dmemRdata;
      if (stb.regWrite && dstIdx != '0) regs[dstIdx] <= wbData;
      if (stb.pcLoad) pc <= stb.pcTarget ? (npc + {immSx[XLEN-3:0], 2'b00}) : npc;
    end
  end

  AST_PC_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pcLoad && !stb.pcTarget) |=> (pc == $past(pc) + 32'd4)); // R2
  AST_ZERO_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.opLoad && rsIdx == '0) |=> (opA == '0)); // R9
endmodule

// File: rtl/mc_risc_seq.sv
module mc_risc_seq
  import mcs_pkg::*;
#(
  parameter int REGS  = 32,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  output logic [XLEN-1:0]  imemAddr,
  input  logic [XLEN-1:0]  imemRdata,
  output logic [XLEN-1:0]  dmemAddr,
  output logic [XLEN-1:0]  dmemWdata,
  input  logic [XLEN-1:0]  dmemRdata,
  output logic             dmemRead,
  output logic             dmemWrite,
  output logic             retire,
  output logic [CNT_W-1:0] cycleCount
);
  strobeT     stb;
  logic [5:0] opcode;
  logic       regsEq;

  mcs_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .opcode (opcode),
    .regsEq (regsEq),
    .stb    (stb),
    .retire (retire)
  );

  mcs_dpath #(.REGS(REGS)) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .imemRdata (imemRdata),
    .dmemRdata (dmemRdata),
    .pc        (imemAddr),
    .opcode    (opcode),
    .regsEq    (regsEq),
    .dmemAddr  (dmemAddr),
    .dmemWdata (dmemWdata)
  );

  assign dmemRead  = stb.memRead;
  assign dmemWrite = stb.memWrite;

  always_ff @(posedge clk) begin
    if (!rstN) cycleCount <= '0;
    else       cycleCount <= cycleCount + 1'b1;
  end
endmodule

// File: tb/mc_risc_seq_tb.sv
module mc_risc_seq_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] imemAddr, imemRdata, dmemAddr, dmemWdata, dmemRdata, cycleCount;
  logic        dmemRead, dmemWrite, retire;

  logic [31:0] imem [256];
  logic [31:0] dmem [256];
  logic [31:0] expMem [256];
  int checks = 0, errors = 0;
  int pcW = 0, slot = 0, skipSlot = -1, haltPc = 0;
  int lastRetire = -1;
  logic [31:0] expPc = '0;
  bit havePc = 0, done = 0, running = 0;

  always #5 clk = ~clk;

  mc_risc_seq dut_i (
    .clk(clk), .rstN(rstN), .imemAddr(imemAddr), .imemRdata(imemRdata),
    .dmemAddr(dmemAddr), .dmemWdata(dmemWdata), .dmemRdata(dmemRdata),
    .dmemRead(dmemRead), .dmemWrite(dmemWrite), .retire(retire), .cycleCount(cycleCount)
  );

  assign imemRdata = imem[imemAddr[9:2]];
  assign dmemRdata = dmem[dmemAddr[9:2]];
  always @(posedge clk) if (dmemWrite) dmem[dmemAddr[9:2]] <= dmemWdata;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] encR(input logic [5:0] fn, input int rd, input int rs, input int rt);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] encI(input logic [5:0] op, input int rt, input int rs, input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic emit(input logic [31:0] w);
    imem[pcW] = w;
    pcW++;
  endtask
  task automatic storeSlot(input int r, input logic [31:0] val);
    emit(encI(6'h2B, r, 0, slot * 4));
    expMem[slot] = val;
    slot++;
  endtask

  function automatic logic [31:0] refRR(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b);
    case (fn)
      6'h20: return a + b;
      6'h22: return a - b;
      6'h24: return a & b;
      6'h25: return a | b;
      6'h26: return a ^ b;
      6'h2A: return (int'(a) < int'(b)) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  // retire monitor: per-class latency (R11) and sequential PC (R2)
  always @(negedge clk) begin
    if (running && !done && rstN && retire) begin
      logic [31:0] w;
      logic [5:0]  op;
      int lat, expLat;
      w  = imem[imemAddr[9:2]];
      op = w[31:26];
      lat = int'(cycleCount) - lastRetire;
      case (op)
        6'h2B:                             expLat = 4;
        6'h00, 6'h08, 6'h0C, 6'h0D, 6'h23: expLat = 5;
        default:                           expLat = 2;
      endcase
      if (op == 6'h04)      check("R8 R11 branch latency", lat, expLat);
      else if (op == 6'h2B) check("R7 R11 store latency", lat, expLat);
      else if (op == 6'h23) check("R6 R11 load latency", lat, expLat);
      else if (op == 6'h00) check("R4 R11 reg-reg latency", lat, expLat);
      else if (expLat == 5) check("R5 R11 reg-imm latency", lat, expLat);
      else                  check("R10 R11 undefined latency", lat, expLat);
      if (havePc) check("R2 sequential pc", imemAddr, expPc);
      havePc = (op != 6'h04);
      expPc  = imemAddr + 32'd4;
      lastRetire = int'(cycleCount);
      if (int'(imemAddr) == haltPc) done = 1;
    end
  end

  initial begin
    int aList[5] = '{5, -7, 32767, -1, 100};
    int bList[5] = '{3, 12, -32768, -1, 100};
    logic [5:0] fns[7] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h26, 6'h2A, 6'h3F};
    for (int i = 0; i < 256; i++) begin
      imem[i] = '0; dmem[i] = '0; expMem[i] = '0;
    end
    // R4 R5 sweep over operand pairs
    for (int p = 0; p < 5; p++) begin
      logic [31:0] a, b;
      a = 32'(aList[p]); b = 32'(bList[p]);
      emit(encI(6'h08, 1, 0, aList[p]));
      emit(encI(6'h08, 2, 0, bList[p]));
      for (int f = 0; f < 7; f++) begin
        emit(encR(fns[f], 3, 1, 2));
        storeSlot(3, refRR(fns[f], a, b));
      end
      emit(encI(6'h08, 4, 1, bList[p])); storeSlot(4, a + b);
      emit(encI(6'h0C, 4, 1, bList[p])); storeSlot(4, a & b);
      emit(encI(6'h0D, 4, 1, bList[p])); storeSlot(4, a | b);
    end
    // R9 register zero
    emit(encI(6'h08, 0, 0, 55)); storeSlot(0, 0);
    emit(encR(6'h20, 0, 1, 1));  storeSlot(0, 0);
    // R6 R3 loads, including a negative offset
    emit(encI(6'h08, 5, 0, -1234));
    storeSlot(5, 32'(-1234));
    emit(encI(6'h23, 6, 0, (slot - 1) * 4));
    emit(encI(6'h08, 7, 6, 1)); storeSlot(7, 32'(-1233));
    emit(encI(6'h08, 8, 0, (slot - 2) * 4 + 8));
    emit(encI(6'h23, 9, 8, -8)); storeSlot(9, 32'(-1234));
    // R10 undefined opcode with fields that would name r10
    emit({6'h3F, 5'd0, 5'd10, 16'h7777});
    storeSlot(10, 0);
    emit(encI(6'h08, 10, 0, 9)); storeSlot(10, 9);
    // R8 taken forward branch skips one store
    emit(encI(6'h08, 11, 0, 7));
    emit(encI(6'h08, 12, 0, 7));
    emit(encI(6'h04, 12, 11, 1));
    skipSlot = slot; emit(encI(6'h2B, 11, 0, slot * 4)); expMem[slot] = 0; slot++;
    storeSlot(12, 7);
    // R8 not-taken branch
    emit(encI(6'h08, 13, 0, 3));
    emit(encI(6'h04, 13, 11, 1));
    storeSlot(13, 3);
    // R8 R3 backward branch loop runs three times
    emit(encI(6'h08, 8, 0, 0));
    emit(encI(6'h08, 9, 0, 3));
    emit(encI(6'h08, 8, 8, 1));
    emit(encI(6'h04, 9, 8, 1));
    emit(encI(6'h04, 0, 0, -3));
    storeSlot(8, 3);
    haltPc = pcW * 4;
    emit(encI(6'h04, 0, 0, -1));

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset pc", imemAddr, 0);
    check("R1 reset count", cycleCount, 0);
    check("R1 reset retire", {31'd0, retire}, 0);
    check("R1 reset write", {31'd0, dmemWrite}, 0);
    rstN = 1'b1;
    running = 1;
    check("R1 first fetch pc", imemAddr, 0);
    check("R1 first count", cycleCount, 0);
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    end
    repeat (4) @(negedge clk);
    for (int s = 0; s < slot; s++) begin
      if (s == skipSlot) check("R8 skipped store", dmem[s], expMem[s]);
      else               check("R3 R4 R5 R6 R7 R9 R10 stored value", dmem[s], expMem[s]);
    end
    check("R8 halt loop pc", imemAddr, haltPc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule